// File: doc/BRIEF.md
# Monitor Output Selector with Reference Clock Dividers

This block drives four front-panel monitor outputs. Each output has its own 6-bit select register, and that register picks one of up to 64 internal one-bit signals. The signals on offer are:

- the 24 per-port multiplicity inputs
- four external inputs and four debug lines
- a decade ladder of generated reference clocks
- a separately chosen timestamp clock
- the results of the coincidence units that sit beside this block

The block also holds a chain of divide-by-ten counters. Fed by a fixed 100 MHz system clock, the chain makes 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz square waves. A small timestamp-select register picks which of those clocks serves as the timestamp clock.

Configuration goes through a plain write/read register port. Addresses 0 to 3 hold the four output selects. Address 4 holds the timestamp select. The fourth external input is a run-inhibit level, and the block forwards it as a status output.

The block has no sequencing state machine. Its only state is the configuration registers, the divider counters and the output flops.

Top module: `mon_out_sel`

## Requirements
- R1: After reset, all four select registers and the timestamp select read 0, every bit of `mon_out` is low, and `run_inhibit` is low.
- R2: Select codes 0 to 23 route `port_mult[code]` to the output. Bit 0 is the first port's first signal, bit 1 is that port's second signal, and so on up to bit 23. The output shows the source value from the previous clock edge, so it lags by one cycle.
- R3: Codes 24 to 27 route `ext_in[0]` to `ext_in[3]`. Codes 28 to 31 route `dbg_in[0]` to `dbg_in[3]`.
- R4: Codes 32 to 36 route the generated clocks. Their periods are 10, 100, 1000, 10000 and 100000 system-clock cycles, in that order, and each is high for exactly half of its period.
- R5: Code 37 routes the timestamp clock. Timestamp-select values 0 to 4 pick the clocks of codes 32 to 36 respectively. The values 5 to 7 fall back to the 10-cycle clock.
- R6: Codes 40 and 41 route `and_res[0]` and `and_res[1]`. Codes 48 to 55 route `mult_res[0..7]`, and codes 56 to 63 route `or_res[0..7]`.
- R7: The unused codes are 38, 39 and 42 to 47. Any of them drives its output low whatever the inputs are.
- R8: Each of the four outputs follows only its own select register. Outputs set to different codes carry different sources in the same cycle.
- R9: `run_inhibit` equals `ext_in[3]` as it was one clock edge earlier.
- R10: A write with `reg_we` high updates one register at the next edge:
  - addresses 0 to 3 store all 6 data bits into that output's select;
  - address 4 stores data bits [2:0] as the timestamp select;
  - writes to addresses 5 to 7 change nothing.
- R11: `reg_rdata` returns, without delay, the addressed register zero-extended to 6 bits, and returns 0 for addresses 5 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0-3 selects, 4 timestamp select) |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Register read data for `reg_addr` |
| port_mult | input | 24 | Per-port multiplicity signals |
| ext_in | input | 4 | External inputs; bit 3 is the run-inhibit level |
| dbg_in | input | 4 | Debug lines |
| and_res | input | 2 | AND-unit results |
| mult_res | input | 8 | Multiplicity-unit results |
| or_res | input | 8 | OR-unit results |
| mon_out | output | 4 | Registered monitor outputs |
| run_inhibit | output | 1 | Registered run-inhibit status |

## Verification
Faults in the select registers or the routing show up at `mon_out` one cycle after the inputs change. The bench drives distinct bit patterns so that a wrong code-to-source mapping, or a swap between outputs, gives a wrong bit at once. A wrong divider counter cannot be seen in a single sample. Instead it appears as a wrong high-cycle count or rising-edge count over one full period window, so the bench measures whole periods for every rung of the ladder and for several timestamp selections.

// File: rtl/mon_pkg.sv
package mon_pkg;
    // Code map of the 64-entry source space; offsets are decoded by the mux.
    localparam int CODE_PORT = 0;
    localparam int N_PORT    = 24;
    localparam int CODE_EXT  = 24;
    localparam int N_EXT     = 4;
    localparam int CODE_DBG  = 28;
    localparam int N_DBG     = 4;
    localparam int CODE_DIV  = 32;
    localparam int CODE_TS   = 37;
    localparam int CODE_AND  = 40;
    localparam int N_AND     = 2;
    localparam int CODE_MULT = 48;
    localparam int N_MULT    = 8;
    localparam int CODE_OR   = 56;
    localparam int N_OR      = 8;
    localparam int TS_W      = 3;
endpackage

// File: rtl/decade_divider.sv
module decade_divider #(
    parameter int STAGES = 5,
    parameter int RATIO  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] clk_out
);
    localparam int CW   = $clog2(RATIO);
    localparam int HALF = RATIO / 2;

    logic [CW-1:0]     cnt_q [STAGES];
    logic [STAGES-1:0] adv;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign adv[k] = 1'b1;
        end else begin : g_next
            assign adv[k] = adv[k-1] && (cnt_q[k-1] == CW'(RATIO - 1));
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q[k] <= '0;
            end else if (adv[k]) begin
                cnt_q[k] <= (cnt_q[k] == CW'(RATIO - 1)) ? '0 : cnt_q[k] + 1'b1;
            end
        end

        assign clk_out[k] = (cnt_q[k] < CW'(HALF));
    end
endmodule

// File: rtl/mon_regs.sv
module mon_regs #(
    parameter int NUM_OUT = 4,
    parameter int SEL_W   = 6,
    parameter int AW      = 3,
    parameter int TS_W    = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [AW-1:0]            addr,
    input  logic [SEL_W-1:0]         wdata,
    output logic [SEL_W-1:0]         rdata,
    output logic [NUM_OUT*SEL_W-1:0] sel_flat,
    output logic [TS_W-1:0]          ts_sel
);
    localparam logic [AW-1:0] TS_ADDR = AW'(NUM_OUT);

    logic [SEL_W-1:0] sel_q [NUM_OUT];
    logic [TS_W-1:0]  ts_q;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_sel
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel_q[i] <= '0;
            end else if (we && addr == AW'(i)) begin
                sel_q[i] <= wdata;
            end
        end
        assign sel_flat[i*SEL_W +: SEL_W] = sel_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else if (we && addr == TS_ADDR) begin
            ts_q <= wdata[TS_W-1:0];
        end
    end

    assign ts_sel = ts_q;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_OUT; i++) begin
            if (addr == AW'(i)) rdata = sel_q[i];
        end
        if (addr == TS_ADDR) rdata = {{(SEL_W-TS_W){1'b0}}, ts_q};
    end
endmodule

// File: rtl/mon_chan.sv
module mon_chan #(
    parameter int SEL_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2**SEL_W-1:0]   src,
    input  logic [SEL_W-1:0]      sel,
    output logic                  out_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= src[sel];
    end
endmodule

// File: rtl/mon_out_sel.sv
module mon_out_sel
    import mon_pkg::*;
#(
    parameter int NUM_OUT    = 4,
    parameter int SEL_W      = 6,
    parameter int AW         = 3,
    parameter int DIV_STAGES = 5,
    parameter int DIV_RATIO  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [AW-1:0]      reg_addr,
    input  logic [SEL_W-1:0]   reg_wdata,
    output logic [SEL_W-1:0]   reg_rdata,
    input  logic [N_PORT-1:0]  port_mult,
    input  logic [N_EXT-1:0]   ext_in,
    input  logic [N_DBG-1:0]   dbg_in,
    input  logic [N_AND-1:0]   and_res,
    input  logic [N_MULT-1:0]  mult_res,
    input  logic [N_OR-1:0]    or_res,
    output logic [NUM_OUT-1:0] mon_out,
    output logic               run_inhibit
);
    localparam int NSRC = 2 ** SEL_W;

    logic [NUM_OUT*SEL_W-1:0] sel_flat;
    logic [TS_W-1:0]          ts_sel;
    logic [DIV_STAGES-1:0]    div_clk;
    logic                     ts_clk;
    logic [NSRC-1:0]          src;

    mon_regs #(.NUM_OUT(NUM_OUT), .SEL_W(SEL_W), .AW(AW), .TS_W(TS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .sel_flat(sel_flat), .ts_sel(ts_sel)
    );

    decade_divider #(.STAGES(DIV_STAGES), .RATIO(DIV_RATIO)) u_div (
        .clk(clk), .rst_n(rst_n), .clk_out(div_clk)
    );

    // Out-of-range timestamp selects fall back to the fastest rung.
    always_comb begin
        ts_clk = div_clk[0];
        for (int k = 0; k < DIV_STAGES; k++) begin
            if (ts_sel == TS_W'(k)) ts_clk = div_clk[k];
        end
    end

    always_comb begin
        src = '0;
        src[CODE_PORT +: N_PORT]    = port_mult;
        src[CODE_EXT  +: N_EXT]     = ext_in;
        src[CODE_DBG  +: N_DBG]     = dbg_in;
        src[CODE_DIV  +: DIV_STAGES] = div_clk;
        src[CODE_TS]                = ts_clk;
        src[CODE_AND  +: N_AND]     = and_res;
        src[CODE_MULT +: N_MULT]    = mult_res;
        src[CODE_OR   +: N_OR]      = or_res;
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        mon_chan #(.SEL_W(SEL_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .src(src),
            .sel(sel_flat[i*SEL_W +: SEL_W]), .out_q(mon_out[i])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_inhibit <= 1'b0;
        else        run_inhibit <= ext_in[N_EXT-1];
    end
endmodule

// File: rtl/mon_out_sel_chk.sv
module mon_out_sel_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [2:0]  reg_addr,
    input logic [5:0]  reg_wdata,
    input logic [23:0] port_mult,
    input logic        ext_hi,
    input logic [5:0]  sel0,
    input logic        out0,
    input logic        run_inhibit
);
    logic past_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    function automatic logic is_unused(input logic [5:0] c);
        return (c == 6'd38) || (c == 6'd39) || (c >= 6'd42 && c <= 6'd47);
    endfunction

    // R9
    run_inhibit_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (run_inhibit == $past(ext_hi)));

    // R7
    unused_code_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && is_unused($past(sel0))) |-> !out0);

    // R2
    port_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(sel0) < 6'd24) |-> (out0 == $past(port_mult[sel0])));

    // R10
    sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0) |=> (sel0 == $past(reg_wdata)));
endmodule

bind mon_out_sel mon_out_sel_chk i_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .port_mult(port_mult), .ext_hi(ext_in[3]),
    .sel0(sel_flat[5:0]), .out0(mon_out[0]), .run_inhibit(run_inhibit)
);

// File: tb/test_mon_out_sel.sv
module test_mon_out_sel;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [5:0]  reg_wdata = '0;
    logic [5:0]  reg_rdata;
    logic [23:0] port_mult = '0;
    logic [3:0]  ext_in = '0;
    logic [3:0]  dbg_in = '0;
    logic [1:0]  and_res = '0;
    logic [7:0]  mult_res = '0;
    logic [7:0]  or_res = '0;
    logic [3:0]  mon_out;
    logic        run_inhibit;

    int checks = 0;
    int errors = 0;
    int sel_m [4] = '{0, 0, 0, 0};

    typedef struct {
        logic [3:0] mo;
        logic       ri;
        string      tag;
    } item_t;
    item_t sb_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mon_out_sel i_mon_out_sel (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .port_mult(port_mult),
        .ext_in(ext_in), .dbg_in(dbg_in), .and_res(and_res), .mult_res(mult_res),
        .or_res(or_res), .mon_out(mon_out), .run_inhibit(run_inhibit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model of the static routing (clock codes are measured separately).
    function automatic logic mdl(input int code);
        if (code < 24)                  return port_mult[code];
        if (code < 28)                  return ext_in[code-24];
        if (code < 32)                  return dbg_in[code-28];
        if (code == 40 || code == 41)   return and_res[code-40];
        if (code >= 48 && code < 56)    return mult_res[code-48];
        if (code >= 56)                 return or_res[code-56];
        return 1'b0;
    endfunction

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(addr); reg_wdata = 6'(data);
        @(negedge clk);
        reg_we = 1'b0;
        if (addr < 4) sel_m[addr] = data;
    endtask

    task automatic rd_chk(input int addr, input int exp, input string req);
        @(negedge clk);
        reg_addr = 3'(addr);
        #1;
        chk(reg_rdata == 6'(exp), req, int'(reg_rdata), exp);
    endtask

    task automatic set4(input int a, input int b, input int c, input int d);
        wr(0, a); wr(1, b); wr(2, c); wr(3, d);
    endtask

    task automatic drive(input logic [23:0] p, input logic [3:0] e, input logic [3:0] d,
                         input logic [1:0] a, input logic [7:0] m, input logic [7:0] o,
                         input string tag);
        item_t it;
        @(negedge clk);
        port_mult = p; ext_in = e; dbg_in = d; and_res = a; mult_res = m; or_res = o;
        for (int i = 0; i < 4; i++) it.mo[i] = mdl(sel_m[i]);
        it.ri  = e[3];
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic flush();
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    // Monitor: compares after the edge that registers the driven inputs.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                chk(mon_out == it.mo, it.tag, int'(mon_out), int'(it.mo));
                chk(run_inhibit == it.ri, "R9 run_inhibit", int'(run_inhibit), int'(it.ri));
            end
        end
    end

    task automatic measure(input int w, output int hi [4], output int rises [4]);
        logic [3:0] prev;
        for (int i = 0; i < 4; i++) begin hi[i] = 0; rises[i] = 0; end
        @(negedge clk);
        prev = mon_out;
        for (int n = 0; n < w; n++) begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                if (mon_out[i]) hi[i]++;
                if (mon_out[i] && !prev[i]) rises[i]++;
            end
            prev = mon_out;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi [4];
        int rs [4];
        ext_in = 4'b1000;
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        chk(mon_out == 4'b0, "R1 mon_out in reset", int'(mon_out), 0);
        chk(run_inhibit == 1'b0, "R1 run_inhibit in reset", int'(run_inhibit), 0);
        @(negedge clk);
        ext_in = '0;
        rst_n = 1'b1;
        for (int a = 0; a < 5; a++) rd_chk(a, 0, "R1 register reset value");

        // R2, R8: port routing, outputs distinct
        set4(5, 23, 0, 12);
        rd_chk(0, 5, "R11 readback sel0");
        rd_chk(1, 23, "R11 readback sel1");
        drive(24'hA5A5A5, 4'h0, 4'h0, 2'b00, 8'h00, 8'h00, "R2 ports A5");
        drive(24'h800021, 4'h0, 4'h0, 2'b00, 8'h00, 8'h00, "R2 ports edges");
        drive(24'h001000, 4'h0, 4'h0, 2'b00, 8'h00, 8'h00, "R8 one-hot bit12");
        drive(24'h7FEFDE, 4'h0, 4'h0, 2'b00, 8'h00, 8'h00, "R2 ports inverse");
        flush();

        // R3, R9: external and debug lines
        set4(24, 27, 28, 31);
        drive(24'hFFFFFF, 4'b1000, 4'b0001, 2'b11, 8'hFF, 8'hFF, "R3 ext3 dbg0");
        drive(24'h000000, 4'b0001, 4'b1000, 2'b00, 8'h00, 8'h00, "R3 ext0 dbg3");
        drive(24'h000000, 4'b1001, 4'b0000, 2'b00, 8'h00, 8'h00, "R9 ext both");
        drive(24'h000000, 4'b0000, 4'b1001, 2'b00, 8'h00, 8'h00, "R3 dbg both");
        flush();

        // R6: coincidence results
        set4(40, 41, 48, 63);
        drive(24'hFFFFFF, 4'h0, 4'h0, 2'b01, 8'h01, 8'h00, "R6 and0 mult0");
        drive(24'h000000, 4'h0, 4'h0, 2'b10, 8'h00, 8'h80, "R6 and1 or7");
        set4(55, 56, 60, 49);
        drive(24'h000000, 4'h0, 4'h0, 2'b00, 8'h80, 8'h11, "R6 mult7 or0 or4");
        drive(24'h000000, 4'h0, 4'h0, 2'b00, 8'h02, 8'hEE, "R6 mult1");
        flush();

        // R7: unused codes stay low with every input high
        set4(38, 39, 42, 47);
        drive(24'hFFFFFF, 4'hF, 4'hF, 2'b11, 8'hFF, 8'hFF, "R7 unused codes low");
        set4(43, 44, 45, 46);
        drive(24'hFFFFFF, 4'hF, 4'hF, 2'b11, 8'hFF, 8'hFF, "R7 unused codes low b");
        flush();

        // R10, R11: ignored addresses, timestamp width
        set4(1, 2, 3, 4);
        wr(6, 63);
        wr(5, 17);
        rd_chk(5, 0, "R11 addr5 reads zero");
        rd_chk(7, 0, "R11 addr7 reads zero");
        rd_chk(0, 1, "R10 sel0 kept after stray write");
        rd_chk(3, 4, "R10 sel3 kept after stray write");
        wr(4, 63);
        rd_chk(4, 7, "R10 ts keeps 3 bits");
        wr(2, 63);
        rd_chk(2, 63, "R10 sel2 full width");

        // R4: clock ladder, whole-period windows
        port_mult = '0; ext_in = '0; dbg_in = '0; and_res = '0; mult_res = '0; or_res = '0;
        set4(32, 33, 34, 35);
        repeat (3) @(negedge clk);
        measure(10000, hi, rs);
        chk(hi[0] == 5000 && rs[0] == 1000, "R4 10-cycle clock", hi[0]*10000+rs[0], 5000*10000+1000);
        chk(hi[1] == 5000 && rs[1] == 100, "R4 100-cycle clock", hi[1]*10000+rs[1], 5000*10000+100);
        chk(hi[2] == 5000 && rs[2] == 10, "R4 1000-cycle clock", hi[2]*10000+rs[2], 5000*10000+10);
        chk(hi[3] == 5000 && rs[3] == 1, "R4 10000-cycle clock", hi[3]*10000+rs[3], 5000*10000+1);

        // R4, R5: slowest rung and timestamp select 4
        wr(4, 4);
        set4(36, 37, 0, 0);
        repeat (3) @(negedge clk);
        measure(100000, hi, rs);
        chk(hi[0] == 50000 && rs[0] == 1, "R4 100000-cycle clock", hi[0], 50000);
        chk(hi[1] == 50000 && rs[1] == 1, "R5 ts=4 slowest clock", hi[1], 50000);

        // R5: timestamp selects and fallback
        wr(0, 37);
        wr(4, 7);
        repeat (3) @(negedge clk);
        measure(100, hi, rs);
        chk(hi[0] == 50 && rs[0] == 10, "R5 ts=7 falls back to fastest", rs[0], 10);
        wr(4, 1);
        repeat (3) @(negedge clk);
        measure(1000, hi, rs);
        chk(hi[0] == 500 && rs[0] == 10, "R5 ts=1 100-cycle clock", rs[0], 10);
        wr(4, 3);
        repeat (3) @(negedge clk);
        measure(10000, hi, rs);
        chk(hi[0] == 5000 && rs[0] == 1, "R5 ts=3 10000-cycle clock", rs[0], 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule